// File: doc/BRIEF.md
# Low-Power Entry Sequencer

This block decides what happens when the core stops in wait-for-interrupt while software has asked for a low-power state. It checks two cancellation conditions during one dedicated cycle. A late interrupt, or a core that is no longer sleeping, cancels entry as a fall-through. A transaction still in flight in the non-volatile-memory or life-cycle agents cancels entry as an abort. If neither condition holds, the block gates the clocks. It then optionally removes main-domain power and parks in the low-power state until an enabled wake request arrives.

Each step of the sequence drives a request and waits for the matching acknowledge before it moves on. Leaving the low-power state undoes the steps in reverse order: power returns first, then the clocks. The clock and power configuration is captured at the moment of entry. A configuration-enable output locks the control settings for the whole trip and unlocks again only when the sequencer is back in the active state.

Top module: `lp_entry_seq`

## Requirements
- R1: Entry starts only when `lp_hint` and `core_wfi` are both 1 in the active state. With `lp_hint` at 0, asserting `core_wfi` changes no output.
- R2: In the cycle after entry starts (the check cycle), if `irq_pending` is 1 or `core_wfi` is 0, the sequencer pulses `fall_through` for exactly one cycle and returns to active. No clock or power request changes.
- R3: In the check cycle, if there is no fall-through condition but `nvm_busy` or `lc_busy` is 1, the sequencer pulses `abort_evt` for exactly one cycle and returns to active. No clock or power request changes.
- R4: When fall-through and abort conditions hold in the same check cycle, only `fall_through` pulses.
- R5: `cfg_en` resets to 1. It goes to 0 on the clock edge that starts entry, and also on a `cfg_lock_clr` pulse. Only a return to the active state sets it back to 1.
- R6: Outside the gated states, `core_clk_en` and `io_clk_en` are 1. Once gating begins, each equals the matching configuration bit captured at entry (1 = clock kept running); both configuration bits reset to 0 in use.
- R7: `main_pd_req` is 1 only after both clock acknowledges match their enables, and only if the captured `cfg_main_keep` is 0 (1 = keep main power).
- R8: In the low-power state, only a bit set in both `wake_req` and `wake_en` starts the exit. The exit first drops `main_pd_req` and waits for `main_pd_ack` to be 0. It then raises both clock enables and waits for both clock acknowledges to be 1 before returning to active.
- R9: Changing the configuration inputs after entry has started has no effect on the clock or power requests of that low-power trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_hint | input | 1 | Software low-power intent |
| core_wfi | input | 1 | Core is sleeping in wait-for-interrupt |
| irq_pending | input | 1 | Interrupt pending at the core |
| nvm_busy | input | 1 | Non-volatile-memory transaction in progress |
| lc_busy | input | 1 | Life-cycle transaction in progress |
| cfg_core_clk_on | input | 1 | Keep core clock in low power |
| cfg_io_clk_on | input | 1 | Keep IO clock in low power |
| cfg_main_keep | input | 1 | Keep main domain powered in low power |
| cfg_lock_clr | input | 1 | Software write clearing the configuration enable |
| wake_req | input | WAKE_W | Wake requests |
| wake_en | input | WAKE_W | Wake enable mask |
| core_clk_ack | input | 1 | Core clock running status |
| io_clk_ack | input | 1 | IO clock running status |
| main_pd_ack | input | 1 | Main domain powered-down status |
| core_clk_en | output | 1 | Core clock enable request |
| io_clk_en | output | 1 | IO clock enable request |
| main_pd_req | output | 1 | Main domain power-down request |
| cfg_en | output | 1 | Control configuration enable |
| fall_through | output | 1 | Fall-through event pulse |
| abort_evt | output | 1 | Abort event pulse |

## Verification
The two cancellation paths can both apply in the same check cycle: an interrupt arriving while a memory agent is still busy. The bench raises `irq_pending` and `nvm_busy` together with the hint and wait-for-interrupt. It expects `fall_through` and no `abort_evt` two edges later. A second collision is a software lock write landing on the cycle that returns the sequencer to active; the return must win. A behavioural reference model judges both cases, and it is compared against every output on every clock.

// File: rtl/lp_entry_seq.sv
module lp_entry_seq #(
  parameter int WAKE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp_hint,
  input  logic              core_wfi,
  input  logic              irq_pending,
  input  logic              nvm_busy,
  input  logic              lc_busy,
  input  logic              cfg_core_clk_on,
  input  logic              cfg_io_clk_on,
  input  logic              cfg_main_keep,
  input  logic              cfg_lock_clr,
  input  logic [WAKE_W-1:0] wake_req,
  input  logic [WAKE_W-1:0] wake_en,
  input  logic              core_clk_ack,
  input  logic              io_clk_ack,
  input  logic              main_pd_ack,
  output logic              core_clk_en,
  output logic              io_clk_en,
  output logic              main_pd_req,
  output logic              cfg_en,
  output logic              fall_through,
  output logic              abort_evt
);

  typedef enum logic [2:0] {
    S_ACTIVE, S_CHECK, S_GATE_CLK, S_GATE_PWR, S_LOW, S_UNGATE_PWR, S_UNGATE_CLK
  } state_t;

  state_t st, st_n;
  logic   snap_core, snap_io, snap_keep;

  wire start      = (st == S_ACTIVE) && lp_hint && core_wfi;
  wire late_irq   = irq_pending || !core_wfi;
  wire mem_busy   = nvm_busy || lc_busy;
  wire clk_gated  = (st == S_GATE_CLK) || (st == S_GATE_PWR) ||
                    (st == S_LOW) || (st == S_UNGATE_PWR);
  wire clk_match  = (core_clk_ack == core_clk_en) && (io_clk_ack == io_clk_en);
  wire wake       = |(wake_req & wake_en);
  wire to_active  = (st != S_ACTIVE) && (st_n == S_ACTIVE);

  assign core_clk_en = clk_gated ? snap_core : 1'b1;
  assign io_clk_en   = clk_gated ? snap_io   : 1'b1;
  assign main_pd_req = ((st == S_GATE_PWR) || (st == S_LOW)) && !snap_keep;

  always_comb begin
    st_n = st;
    case (st)
      S_ACTIVE:     if (start) st_n = S_CHECK;
      S_CHECK:      if (late_irq || mem_busy) st_n = S_ACTIVE;
                    else st_n = S_GATE_CLK;
      S_GATE_CLK:   if (clk_match) st_n = S_GATE_PWR;
      S_GATE_PWR:   if (main_pd_ack == main_pd_req) st_n = S_LOW;
      S_LOW:        if (wake) st_n = S_UNGATE_PWR;
      S_UNGATE_PWR: if (!main_pd_ack) st_n = S_UNGATE_CLK;
      S_UNGATE_CLK: if (core_clk_ack && io_clk_ack) st_n = S_ACTIVE;
      default:      st_n = S_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_ACTIVE;
      cfg_en       <= 1'b1;
      fall_through <= 1'b0;
      abort_evt    <= 1'b0;
      snap_core    <= 1'b0;
      snap_io      <= 1'b0;
      snap_keep    <= 1'b1;
    end else begin
      st           <= st_n;
      fall_through <= (st == S_CHECK) && late_irq;
      abort_evt    <= (st == S_CHECK) && !late_irq && mem_busy;
      if (to_active)                 cfg_en <= 1'b1;
      else if (start || cfg_lock_clr) cfg_en <= 1'b0;
      if (start) begin
        snap_core <= cfg_core_clk_on;
        snap_io   <= cfg_io_clk_on;
        snap_keep <= cfg_main_keep;
      end
    end
  end

  assert_one_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_through && abort_evt));

  assert_ft_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_through |=> !fall_through);

  assert_abort_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !abort_evt);

  assert_cancel_no_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_through || abort_evt) |-> (core_clk_en && io_clk_en && !main_pd_req));

  assert_unlock_on_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_en) |-> (st == S_ACTIVE && $past(st) != S_ACTIVE));

  assert_pd_after_clk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_pd_req) |-> $past(core_clk_ack == core_clk_en && io_clk_ack == io_clk_en));

  assert_clk_after_power_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(core_clk_en) || $rose(io_clk_en)) |-> $past(!main_pd_ack && !main_pd_req));

endmodule

// File: tb/test_lp_entry_seq.sv
`timescale 1ns/1ps
module test_lp_entry_seq;
  localparam int WAKE_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp_hint = 0, core_wfi = 0, irq_pending = 0, nvm_busy = 0, lc_busy = 0;
  logic cfg_core_clk_on = 0, cfg_io_clk_on = 0, cfg_main_keep = 1, cfg_lock_clr = 0;
  logic [WAKE_W-1:0] wake_req = '0, wake_en = '0;
  logic core_clk_ack, io_clk_ack, main_pd_ack;
  logic core_clk_en, io_clk_en, main_pd_req, cfg_en, fall_through, abort_evt;
  logic c1, i1, p1;

  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  lp_entry_seq #(.WAKE_W(WAKE_W)) i_lp_entry_seq (
    .clk(clk), .rst_n(rst_n), .lp_hint(lp_hint), .core_wfi(core_wfi),
    .irq_pending(irq_pending), .nvm_busy(nvm_busy), .lc_busy(lc_busy),
    .cfg_core_clk_on(cfg_core_clk_on), .cfg_io_clk_on(cfg_io_clk_on),
    .cfg_main_keep(cfg_main_keep), .cfg_lock_clr(cfg_lock_clr),
    .wake_req(wake_req), .wake_en(wake_en),
    .core_clk_ack(core_clk_ack), .io_clk_ack(io_clk_ack), .main_pd_ack(main_pd_ack),
    .core_clk_en(core_clk_en), .io_clk_en(io_clk_en), .main_pd_req(main_pd_req),
    .cfg_en(cfg_en), .fall_through(fall_through), .abort_evt(abort_evt));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c1 <= 1; core_clk_ack <= 1; i1 <= 1; io_clk_ack <= 1; p1 <= 0; main_pd_ack <= 0;
    end else begin
      c1 <= core_clk_en; core_clk_ack <= c1;
      i1 <= io_clk_en;   io_clk_ack   <= i1;
      p1 <= main_pd_req; main_pd_ack  <= p1;
    end

  // Reference model: phase 0 active, 1 check, 2 gate clocks, 3 gate power,
  // 4 low power, 5 restore power, 6 restore clocks.
  int   ph;
  logic m_cfg, m_ft, m_ab, m_core, m_io, m_keep;

  function automatic logic e_core();  return (ph >= 2 && ph <= 5) ? m_core : 1'b1; endfunction
  function automatic logic e_io();    return (ph >= 2 && ph <= 5) ? m_io   : 1'b1; endfunction
  function automatic logic e_pd();    return (ph == 3 || ph == 4) && !m_keep; endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph <= 0; m_cfg <= 1; m_ft <= 0; m_ab <= 0; m_core <= 0; m_io <= 0; m_keep <= 1;
    end else begin
      m_ft <= 0; m_ab <= 0;
      if (ph == 0) begin
        if (lp_hint && core_wfi) begin
          ph <= 1; m_cfg <= 0;
          m_core <= cfg_core_clk_on; m_io <= cfg_io_clk_on; m_keep <= cfg_main_keep;
        end else if (cfg_lock_clr) m_cfg <= 0;
      end else if (ph == 1) begin
        if (irq_pending || !core_wfi) begin ph <= 0; m_ft <= 1; m_cfg <= 1; end
        else if (nvm_busy || lc_busy) begin ph <= 0; m_ab <= 1; m_cfg <= 1; end
        else ph <= 2;
      end else begin
        if (cfg_lock_clr) m_cfg <= 0;
        case (ph)
          2: if (core_clk_ack == e_core() && io_clk_ack == e_io()) ph <= 3;
          3: if (main_pd_ack == e_pd()) ph <= 4;
          4: if ((wake_req & wake_en) != 0) ph <= 5;
          5: if (!main_pd_ack) ph <= 6;
          6: if (core_clk_ack && io_clk_ack) begin ph <= 0; m_cfg <= 1; end
          default: ph <= 0;
        endcase
      end
    end

  task automatic chk(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk)
    if (rst_n) begin
      chk("R6 core_clk_en", core_clk_en, e_core());
      chk("R6 io_clk_en",   io_clk_en,   e_io());
      chk("R7 main_pd_req", main_pd_req, e_pd());
      chk("R5 cfg_en",      cfg_en,      m_cfg);
      chk("R2 fall_through", fall_through, m_ft);
      chk("R3 abort_evt",   abort_evt,   m_ab);
    end

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_ph(int p);
    for (int k = 0; k < 60 && ph != p; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #160000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  task automatic cancel_try(logic irq, logic nvm, logic lc, logic exp_ft, logic exp_ab, string tag);
    lp_hint = 1; core_wfi = 1; irq_pending = irq; nvm_busy = nvm; lc_busy = lc;
    @(negedge clk);
    chk({tag, " lock at entry R5"}, cfg_en, 1'b0);
    @(negedge clk);
    chk({tag, " fall_through"}, fall_through, exp_ft);
    chk({tag, " abort_evt"}, abort_evt, exp_ab);
    chk({tag, " no gating"}, core_clk_en & io_clk_en & ~main_pd_req, 1'b1);
    lp_hint = 0; core_wfi = 0; irq_pending = 0; nvm_busy = 0; lc_busy = 0;
    @(negedge clk);
    chk({tag, " single pulse"}, fall_through | abort_evt, 1'b0);
    chk({tag, " unlocked R5"}, cfg_en, 1'b1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    chk("R5 reset cfg_en", cfg_en, 1'b1);
    chk("R6 reset clocks", core_clk_en & io_clk_en, 1'b1);
    chk("R7 reset pd", main_pd_req, 1'b0);

    core_wfi = 1; lp_hint = 0;
    cyc(5);
    chk("R1 no hint keeps cfg_en", cfg_en, 1'b1);
    chk("R1 no hint keeps clocks", core_clk_en & io_clk_en, 1'b1);
    core_wfi = 0;
    cyc(2);

    cancel_try(1, 0, 0, 1, 0, "R2 irq");
    cancel_try(0, 1, 0, 0, 1, "R3 nvm");
    cancel_try(0, 0, 1, 0, 1, "R3 lc");
    cancel_try(1, 1, 1, 1, 0, "R4 both");

    cfg_core_clk_on = 0; cfg_io_clk_on = 1; cfg_main_keep = 0; wake_en = 8'h0F;
    lp_hint = 1; core_wfi = 1;
    wait_ph(4);
    lp_hint = 0;
    @(negedge clk);
    chk("R6 core gated", core_clk_en, 1'b0);
    chk("R6 io kept", io_clk_en, 1'b1);
    chk("R7 pd asserted", main_pd_req, 1'b1);
    cfg_core_clk_on = 1; cfg_main_keep = 1;
    cyc(3);
    chk("R9 snapshot core", core_clk_en, 1'b0);
    chk("R9 snapshot pd", main_pd_req, 1'b1);
    wake_req = 8'hF0;
    cyc(5);
    chk("R8 masked wake ignored", main_pd_req, 1'b1);
    wake_req = 8'h01;
    wait_ph(5);
    @(negedge clk);
    chk("R8 power first", main_pd_req, 1'b0);
    chk("R8 clocks still gated", core_clk_en, 1'b0);
    wake_req = 0; core_wfi = 0;
    wait_ph(0);
    @(negedge clk);
    chk("R8 back active clocks", core_clk_en & io_clk_en, 1'b1);
    chk("R5 unlocked after trip", cfg_en, 1'b1);

    cfg_core_clk_on = 1; cfg_io_clk_on = 0; cfg_main_keep = 1; wake_en = 8'h80;
    lp_hint = 1; core_wfi = 1;
    wait_ph(4);
    lp_hint = 0;
    cyc(4);
    chk("R7 power kept", main_pd_req, 1'b0);
    chk("R6 io gated", io_clk_en, 1'b0);
    chk("R6 core kept", core_clk_en, 1'b1);
    wake_req = 8'h80;
    wait_ph(0);
    wake_req = 0; core_wfi = 0;
    cyc(2);

    cfg_lock_clr = 1;
    @(negedge clk);
    cfg_lock_clr = 0;
    chk("R5 software clear", cfg_en, 1'b0);
    cyc(4);
    chk("R5 stays cleared", cfg_en, 1'b0);
    lp_hint = 1; core_wfi = 1; irq_pending = 1;
    cyc(1);
    cfg_lock_clr = 1;
    cyc(1);
    cfg_lock_clr = 0; lp_hint = 0; core_wfi = 0; irq_pending = 0;
    chk("R5 return beats clear", cfg_en, 1'b1);
    cyc(3);
    finish_run();
  end
endmodule